// File: doc/BRIEF.md
# Unordered late-binding load-store queue bank

This block is one bank of a load-store queue. A slot is claimed only when a load or store issues, never at dispatch. Each slot is taken from a free pool, so a slot number says nothing about program order. Every slot keeps its own explicit age, and all ordering questions are answered by comparing that stored age with a search key. A slot holds the access address, the age, a load/store flag, byte enables and, for stores, the data.

An arriving store looks for loads at the same address that are younger than itself and reports an ordering violation. An arriving load looks for stores at the same address that are strictly older than itself and builds its forwarded bytes from them. With zero or one such store the result comes out in the next cycle. With several, the matching slots are visited one per cycle and the bytes are merged by age, so the scan order does not matter. A commit port names an age, frees that slot and, for a store, presents the address, data and byte enables for write-back. A flush port frees every slot at or above a given age. An issue that finds no free slot is dropped and raises an overflow pulse, which the recovery logic outside this bank acts on.

Top module: `ulsq_bank`

## Requirements
- R1: After reset every slot is free, issueReady is 1 and overflow, violation, fwdValid, commitOutValid, fwdMask and fwdData are 0.
- R2: An issue accepted while at least one slot is free takes a slot. An issue accepted while all ENTRIES slots are in use leaves no slot behind, and overflow is 1 for exactly the cycle after that issue edge.
- R3: A commit whose age equals the age of an occupied slot frees that slot. If that slot holds a store, commitOutValid is 1 in the next cycle with that store's commitAddr, commitData and commitBe. A commit for a load slot or for an age held by no slot leaves commitOutValid at 0.
- R4: An issue sees the occupancy as it stood before the edge, so an issue to a full bank in the same cycle as a freeing commit still overflows. The freed slot can be taken from the next cycle on.
- R5: A store issue raises violation in the next cycle exactly when some occupied load slot has the same address and a strictly greater age. An equal age, an older load or a different address gives no violation.
- R6: A load issue with no older store at its address gives fwdValid in the next cycle with fwdMask = 0 and fwdData = 0.
- R7: Only stores with an age strictly below the load's age take part in forwarding. With one such store, fwdValid is 1 in the next cycle and fwdMask = loadBe & storeBe, where bit b of a byte-enable or of fwdMask covers fwdData bits 8b+7 down to 8b.
- R8: With N >= 2 older matching stores, the load's issue edge counts as the first of N edges and fwdValid is 1 after the Nth. issueReady is 0 between those edges, and an issue presented while issueReady is 0 is ignored and leaves no slot behind.
- R9: Each forwarded byte comes from the youngest of the older matching stores that enable it, whatever the slot order. Bytes that no such store enables have fwdMask bit 0 and read 0 in fwdData.
- R10: A flush frees, at its edge, every slot whose age is greater than or equal to flushAge. A later commit of such an age gives no commitOutValid.
- R11: Ages compare as unsigned values with no wraparound, so age 0 is older than age 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A load or store issues this cycle |
| issueIsStore | input | 1 | 1 for a store, 0 for a load |
| issueAddr | input | ADDR_W | Access address |
| issueAge | input | AGE_W | Program-order age, larger means younger |
| issueBe | input | DATA_W/8 | Byte enables of the access |
| issueData | input | DATA_W | Store data |
| issueReady | output | 1 | 0 while a multi-store forward scan runs |
| commitValid | input | 1 | Commit request |
| commitAge | input | AGE_W | Age to retire |
| flushValid | input | 1 | Flush request |
| flushAge | input | AGE_W | Slots at or above this age are freed |
| overflow | output | 1 | Issue dropped because no slot was free |
| violation | output | 1 | Store found a younger load to the same address |
| fwdValid | output | 1 | Forwarding result is present |
| fwdData | output | DATA_W | Forwarded bytes, uncovered bytes zero |
| fwdMask | output | DATA_W/8 | Bytes supplied by older stores |
| commitOutValid | output | 1 | A store was retired and is presented |
| commitAddr | output | ADDR_W | Address of the retired store |
| commitData | output | DATA_W | Data of the retired store |
| commitBe | output | DATA_W/8 | Byte enables of the retired store |

## Verification
Issue and slot release can fall in the same cycle. The bench fills the bank to exactly its capacity and then presents a store together with a commit of an occupied age on one edge. It expects both overflow and the committed store's write-back in the following cycle, and expects a later issue to be accepted. A second collision is a commit landing on an age already removed by a flush, which must produce no write-back.

// File: rtl/ulsq_pkg.sv
package ulsq_pkg;
  // Strobes from the control into the datapath, one cycle's worth.
  typedef struct packed {
    logic alloc;       // write the issuing op into allocSlot
    logic mergeClear;  // start a new forward merge with the load's enables
    logic mergeTake;   // merge the store held in scanSlot
    logic fwdFire;     // register the merged result on the outputs
    logic commitFire;  // register commitSlot's fields on the outputs
  } lsqStrobe_t;
endpackage

// File: rtl/ulsq_datapath.sv
module ulsq_datapath
  import ulsq_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 64,
  parameter int AGE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  lsqStrobe_t                 strb,
  input  logic [$clog2(ENTRIES)-1:0] allocSlot,
  input  logic [$clog2(ENTRIES)-1:0] scanSlot,
  input  logic [$clog2(ENTRIES)-1:0] commitSlot,
  input  logic                       inStore,
  input  logic [ADDR_W-1:0]          inAddr,
  input  logic [AGE_W-1:0]           inAge,
  input  logic [DATA_W/8-1:0]        inBe,
  input  logic [DATA_W-1:0]          inData,
  input  logic [AGE_W-1:0]           cmtAge,
  input  logic [AGE_W-1:0]           flushAge,
  output logic [ENTRIES-1:0]         addrEqVec,
  output logic [ENTRIES-1:0]         olderVec,
  output logic [ENTRIES-1:0]         youngerVec,
  output logic [ENTRIES-1:0]         cmtEqVec,
  output logic [ENTRIES-1:0]         flushVec,
  output logic [ENTRIES-1:0]         storeVec,
  output logic [DATA_W-1:0]          fwdData,
  output logic [DATA_W/8-1:0]        fwdMask,
  output logic [ADDR_W-1:0]          commitAddr,
  output logic [DATA_W-1:0]          commitData,
  output logic [DATA_W/8-1:0]        commitBe
);
  localparam int NB = DATA_W / 8;

  logic [ADDR_W-1:0] entAddr [ENTRIES];
  logic [AGE_W-1:0]  entAge  [ENTRIES];
  logic [NB-1:0]     entBe   [ENTRIES];
  logic [DATA_W-1:0] entData [ENTRIES];

  always_ff @(posedge clk) begin
    if (strb.alloc) begin
      entAddr[allocSlot]  <= inAddr;
      entAge[allocSlot]   <= inAge;
      entBe[allocSlot]    <= inBe;
      entData[allocSlot]  <= inData;
      storeVec[allocSlot] <= inStore;
    end
  end

  // Address CAM and magnitude-comparing age CAM, one lane per slot.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cam
    assign addrEqVec[i]  = (entAddr[i] == inAddr);
    assign olderVec[i]   = (entAge[i] <  inAge);
    assign youngerVec[i] = (entAge[i] >  inAge);
    assign cmtEqVec[i]   = (entAge[i] == cmtAge);
    assign flushVec[i]   = (entAge[i] >= flushAge);
  end

  // Byte-wise merge: a byte is replaced only by a younger store.
  logic [NB-1:0]     mCov, mBe, nCov, effBe;
  logic [AGE_W-1:0]  mAge [NB];
  logic [AGE_W-1:0]  nAge [NB];
  logic [DATA_W-1:0] mData, nData;

  always_comb begin
    effBe = strb.mergeClear ? inBe : mBe;
    for (int b = 0; b < NB; b++) begin
      nCov[b]        = strb.mergeClear ? 1'b0 : mCov[b];
      nAge[b]        = mAge[b];
      nData[8*b +: 8] = nCov[b] ? mData[8*b +: 8] : 8'h00;
      if (strb.mergeTake && effBe[b] && entBe[scanSlot][b] &&
          (!nCov[b] || entAge[scanSlot] > mAge[b])) begin
        nCov[b]         = 1'b1;
        nAge[b]         = entAge[scanSlot];
        nData[8*b +: 8] = entData[scanSlot][8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mCov <= '0; mBe <= '0; mData <= '0;
      for (int b = 0; b < NB; b++) mAge[b] <= '0;
      fwdData <= '0; fwdMask <= '0;
      commitAddr <= '0; commitData <= '0; commitBe <= '0;
    end else begin
      if (strb.mergeClear) mBe <= inBe;
      if (strb.mergeClear || strb.mergeTake) begin
        mCov  <= nCov;
        mData <= nData;
        for (int b = 0; b < NB; b++) mAge[b] <= nAge[b];
      end
      if (strb.fwdFire) begin
        fwdData <= nData;
        fwdMask <= nCov;
      end
      if (strb.commitFire) begin
        commitAddr <= entAddr[commitSlot];
        commitData <= entData[commitSlot];
        commitBe   <= entBe[commitSlot];
      end
    end
  end
endmodule

// File: rtl/ulsq_ctrl.sv
module ulsq_ctrl
  import ulsq_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issueValid,
  input  logic                       issueIsStore,
  input  logic                       commitValid,
  input  logic                       flushValid,
  input  logic [ENTRIES-1:0]         addrEqVec,
  input  logic [ENTRIES-1:0]         olderVec,
  input  logic [ENTRIES-1:0]         youngerVec,
  input  logic [ENTRIES-1:0]         cmtEqVec,
  input  logic [ENTRIES-1:0]         flushVec,
  input  logic [ENTRIES-1:0]         storeVec,
  output lsqStrobe_t                 strb,
  output logic [$clog2(ENTRIES)-1:0] allocSlot,
  output logic [$clog2(ENTRIES)-1:0] scanSlot,
  output logic [$clog2(ENTRIES)-1:0] commitSlot,
  output logic [ENTRIES-1:0]         occVec,
  output logic                       issueReady,
  output logic                       overflow,
  output logic                       violation,
  output logic                       fwdValid,
  output logic                       commitOutValid
);
  localparam int SLOT_W = $clog2(ENTRIES);
  localparam logic [ENTRIES-1:0] ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

  function automatic logic [SLOT_W-1:0] lowIdx(input logic [ENTRIES-1:0] v);
    lowIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) lowIdx = SLOT_W'(i);
  endfunction

  logic               scanning;
  logic [ENTRIES-1:0] pend, fwdHits, violHits, cmtHits, pick, remain;
  logic [ENTRIES-1:0] allocMask, cmtMask, flMask;
  logic               accept, hasFree, doAlloc, loadGo, cmtGo;

  always_comb begin
    accept   = issueValid && !scanning;
    hasFree  = ~&occVec;
    doAlloc  = accept && hasFree;
    loadGo   = doAlloc && !issueIsStore;
    fwdHits  = occVec & storeVec & addrEqVec & olderVec;
    violHits = occVec & ~storeVec & addrEqVec & youngerVec;
    pick     = scanning ? pend : fwdHits;
    remain   = pick & (pick - ONE);
    allocSlot = lowIdx(~occVec);
    scanSlot  = lowIdx(pick);
    cmtHits   = occVec & cmtEqVec;
    cmtGo     = commitValid && (|cmtHits);
    commitSlot = lowIdx(cmtHits);
    allocMask = doAlloc ? (ONE << allocSlot) : '0;
    cmtMask   = cmtGo ? (ONE << commitSlot) : '0;
    flMask    = flushValid ? (occVec & flushVec) : '0;

    strb.alloc      = doAlloc;
    strb.mergeClear = loadGo;
    strb.mergeTake  = (loadGo && (|fwdHits)) || scanning;
    strb.fwdFire    = (loadGo || scanning) && (remain == '0);
    strb.commitFire = cmtGo;
  end

  assign issueReady = !scanning;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occVec <= '0; scanning <= 1'b0; pend <= '0;
      overflow <= 1'b0; violation <= 1'b0;
      fwdValid <= 1'b0; commitOutValid <= 1'b0;
    end else begin
      occVec   <= (occVec & ~cmtMask & ~flMask) | allocMask;
      scanning <= (scanning || loadGo) && (remain != '0);
      pend     <= remain;
      overflow <= accept && !hasFree;
      violation <= doAlloc && issueIsStore && (|violHits);
      fwdValid <= strb.fwdFire;
      commitOutValid <= cmtGo && storeVec[commitSlot];
    end
  end
endmodule

// File: rtl/ulsq_bank.sv
module ulsq_bank
  import ulsq_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 40,
  parameter int DATA_W  = 64,
  parameter int AGE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issueValid,
  input  logic                issueIsStore,
  input  logic [ADDR_W-1:0]   issueAddr,
  input  logic [AGE_W-1:0]    issueAge,
  input  logic [DATA_W/8-1:0] issueBe,
  input  logic [DATA_W-1:0]   issueData,
  output logic                issueReady,
  input  logic                commitValid,
  input  logic [AGE_W-1:0]    commitAge,
  input  logic                flushValid,
  input  logic [AGE_W-1:0]    flushAge,
  output logic                overflow,
  output logic                violation,
  output logic                fwdValid,
  output logic [DATA_W-1:0]   fwdData,
  output logic [DATA_W/8-1:0] fwdMask,
  output logic                commitOutValid,
  output logic [ADDR_W-1:0]   commitAddr,
  output logic [DATA_W-1:0]   commitData,
  output logic [DATA_W/8-1:0] commitBe
);
  localparam int SLOT_W = $clog2(ENTRIES);

  lsqStrobe_t         strb;
  logic [SLOT_W-1:0]  allocSlot, scanSlot, commitSlot;
  logic [ENTRIES-1:0] addrEqVec, olderVec, youngerVec, cmtEqVec, flushVec, storeVec;
  logic [ENTRIES-1:0] occVec;

  ulsq_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueIsStore(issueIsStore),
    .commitValid(commitValid), .flushValid(flushValid),
    .addrEqVec(addrEqVec), .olderVec(olderVec), .youngerVec(youngerVec),
    .cmtEqVec(cmtEqVec), .flushVec(flushVec), .storeVec(storeVec),
    .strb(strb), .allocSlot(allocSlot), .scanSlot(scanSlot),
    .commitSlot(commitSlot), .occVec(occVec), .issueReady(issueReady),
    .overflow(overflow), .violation(violation), .fwdValid(fwdValid),
    .commitOutValid(commitOutValid)
  );

  ulsq_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .allocSlot(allocSlot), .scanSlot(scanSlot), .commitSlot(commitSlot),
    .inStore(issueIsStore), .inAddr(issueAddr), .inAge(issueAge),
    .inBe(issueBe), .inData(issueData), .cmtAge(commitAge), .flushAge(flushAge),
    .addrEqVec(addrEqVec), .olderVec(olderVec), .youngerVec(youngerVec),
    .cmtEqVec(cmtEqVec), .flushVec(flushVec), .storeVec(storeVec),
    .fwdData(fwdData), .fwdMask(fwdMask),
    .commitAddr(commitAddr), .commitData(commitData), .commitBe(commitBe)
  );
endmodule

// File: rtl/ulsq_checker.sv
module ulsq_checker #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                issueValid,
  input logic                issueIsStore,
  input logic                issueReady,
  input logic                commitValid,
  input logic                overflow,
  input logic                violation,
  input logic                fwdValid,
  input logic [DATA_W-1:0]   fwdData,
  input logic [DATA_W/8-1:0] fwdMask,
  input logic                commitOutValid,
  input logic [ENTRIES-1:0]  occVec
);
  logic [DATA_W-1:0] maskBits;
  for (genvar b = 0; b < DATA_W/8; b++) begin : g_exp
    assign maskBits[8*b +: 8] = {8{fwdMask[b]}};
  end

  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(&occVec)); // R2
  AST_NO_OVF_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueReady && !(&occVec)) |=> !overflow); // R2
  AST_VIOL_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> $past(issueValid && issueReady && issueIsStore)); // R5
  AST_NO_FWD_WHILE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    !issueReady |-> !fwdValid); // R8
  AST_CMT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    commitOutValid |-> $past(commitValid)); // R3
  AST_UNCOVERED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fwdValid |-> ((fwdData & ~maskBits) == '0)); // R9
endmodule

bind ulsq_bank ulsq_checker #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issueIsStore(issueIsStore),
  .issueReady(issueReady), .commitValid(commitValid), .overflow(overflow),
  .violation(violation), .fwdValid(fwdValid), .fwdData(fwdData), .fwdMask(fwdMask),
  .commitOutValid(commitOutValid), .occVec(occVec)
);

// File: tb/test_ulsq_bank.sv
module test_ulsq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issueValid = 0, issueIsStore = 0;
  logic [39:0] issueAddr = '0;
  logic [7:0]  issueAge = '0, issueBe = '0;
  logic [63:0] issueData = '0;
  logic        issueReady;
  logic        commitValid = 0, flushValid = 0;
  logic [7:0]  commitAge = '0, flushAge = '0;
  logic        overflow, violation, fwdValid, commitOutValid;
  logic [63:0] fwdData, commitData;
  logic [7:0]  fwdMask, commitBe;
  logic [39:0] commitAddr;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  ulsq_bank i_ulsq_bank (.*);

  typedef struct packed {
    logic        st;
    logic [39:0] addr;
    logic [7:0]  age;
    logic [7:0]  be;
    logic [63:0] data;
    logic        expViol;
    logic [7:0]  expMask;
    logic [63:0] expData;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 40'h100, 8'd10, 8'hFF, 64'h1111111111111111, 1'b0, 8'h00, 64'h0},
    '{1'b0, 40'h100, 8'd20, 8'hFF, 64'h0, 1'b0, 8'hFF, 64'h1111111111111111},
    '{1'b0, 40'h100, 8'd5,  8'hFF, 64'h0, 1'b0, 8'h00, 64'h0},
    '{1'b1, 40'h100, 8'd15, 8'h0F, 64'h2222222222222222, 1'b1, 8'h00, 64'h0},
    '{1'b0, 40'h100, 8'd15, 8'hFF, 64'h0, 1'b0, 8'hFF, 64'h1111111111111111},
    '{1'b1, 40'h200, 8'd25, 8'hF0, 64'h3333333333333333, 1'b0, 8'h00, 64'h0},
    '{1'b0, 40'h200, 8'd26, 8'h3C, 64'h0, 1'b0, 8'h30, 64'h0000333300000000},
    '{1'b1, 40'h300, 8'd40, 8'hFF, 64'h0, 1'b0, 8'h00, 64'h0},
    '{1'b1, 40'h100, 8'd12, 8'hFF, 64'h4444444444444444, 1'b1, 8'h00, 64'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; outputs are read one falling edge later.
  task automatic issueOp(input logic st, input logic [39:0] a, input logic [7:0] age,
                         input logic [7:0] be, input logic [63:0] d);
    issueValid = 1; issueIsStore = st; issueAddr = a; issueAge = age;
    issueBe = be; issueData = d;
    @(negedge clk);
    issueValid = 0;
  endtask

  task automatic commitOp(input logic [7:0] age);
    commitValid = 1; commitAge = age;
    @(negedge clk);
    commitValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired, all requirements unchecked");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 issueReady", 64'(issueReady), 64'd1);
    check("R1 quiet outputs", 64'({overflow, violation, fwdValid, commitOutValid}), 64'd0);
    check("R1 fwdMask", 64'(fwdMask), 64'd0);
    check("R1 fwdData", fwdData, 64'd0);

    // Vector table: R5, R6, R7, R9
    foreach (VEC[i]) begin
      issueOp(VEC[i].st, VEC[i].addr, VEC[i].age, VEC[i].be, VEC[i].data);
      check($sformatf("R5 violation v%0d", i), 64'(violation), 64'(VEC[i].expViol));
      check($sformatf("R6 fwdValid v%0d", i), 64'(fwdValid), 64'(!VEC[i].st));
      if (!VEC[i].st) begin
        check($sformatf("R7 fwdMask v%0d", i), 64'(fwdMask), 64'(VEC[i].expMask));
        check($sformatf("R9 fwdData v%0d", i), fwdData, VEC[i].expData);
      end
    end

    // R8/R9: three older stores in slot order age 10, 15, 12
    issueValid = 1; issueIsStore = 0; issueAddr = 40'h100; issueAge = 8'd30; issueBe = 8'hFF;
    @(negedge clk);
    check("R8 busy after edge 1", 64'({issueReady, fwdValid}), 64'd0);
    issueIsStore = 1; issueAddr = 40'h500; issueAge = 8'd50; issueData = 64'hDEAD;
    @(negedge clk);
    issueValid = 0;
    check("R8 busy after edge 2", 64'({issueReady, fwdValid}), 64'd0);
    @(negedge clk);
    check("R8 result after edge 3", 64'({issueReady, fwdValid}), 64'd3);
    check("R9 merged mask", 64'(fwdMask), 64'hFF);
    check("R9 youngest bytes win", fwdData, 64'h4444444422222222);

    // R3 commit
    commitOp(8'd10);
    check("R3 store retire valid", 64'(commitOutValid), 64'd1);
    check("R3 retire addr", 64'(commitAddr), 64'h100);
    check("R3 retire data", commitData, 64'h1111111111111111);
    check("R3 retire be", 64'(commitBe), 64'hFF);
    commitOp(8'd20);
    check("R3 load retire silent", 64'(commitOutValid), 64'd0);
    commitOp(8'd50);
    check("R8 ignored issue left no slot", 64'(commitOutValid), 64'd0);

    // R2 fill to capacity: 8 occupied now
    issueOp(1'b1, 40'h600, 8'd60, 8'hFF, 64'h6);
    check("R2 no overflow with room", 64'(overflow), 64'd0);
    for (int i = 0; i < 23; i++) begin
      issueOp(1'b1, 40'h1000 + 40'(i), 8'(100 + i), 8'hFF, 64'(i));
      check($sformatf("R2 fill %0d", i), 64'(overflow), 64'd0);
    end
    issueOp(1'b1, 40'hA00, 8'd200, 8'hFF, 64'hA);
    check("R2 overflow when full", 64'(overflow), 64'd1);
    @(negedge clk);
    check("R2 overflow one cycle", 64'(overflow), 64'd0);
    commitOp(8'd200);
    check("R2 dropped op left no slot", 64'(commitOutValid), 64'd0);

    // R4 issue and commit on the same edge while full
    issueValid = 1; issueIsStore = 1; issueAddr = 40'h700; issueAge = 8'd201;
    issueBe = 8'hFF; issueData = 64'h7;
    commitValid = 1; commitAge = 8'd100;
    @(negedge clk);
    issueValid = 0; commitValid = 0;
    check("R4 overflow despite commit", 64'(overflow), 64'd1);
    check("R4 commit still retires", 64'(commitOutValid), 64'd1);
    check("R4 commit addr", 64'(commitAddr), 64'h1000);
    issueOp(1'b1, 40'h702, 8'd202, 8'hFF, 64'h72);
    check("R4 freed slot reused", 64'(overflow), 64'd0);
    commitOp(8'd202);
    check("R4 reused slot holds store", 64'(commitAddr), 64'h702);

    // R10 flush of ages >= 100
    flushValid = 1; flushAge = 8'd100;
    @(negedge clk);
    flushValid = 0;
    commitOp(8'd110);
    check("R10 flushed age gone", 64'(commitOutValid), 64'd0);
    commitOp(8'd25);
    check("R10 older store kept", 64'(commitOutValid), 64'd1);
    check("R10 kept store data", commitData, 64'h3333333333333333);
    check("R10 kept store be", 64'(commitBe), 64'hF0);

    // R11 unsigned ages, no wrap
    issueOp(1'b1, 40'h800, 8'd0, 8'hFF, 64'h5555555555555555);
    issueOp(1'b0, 40'h800, 8'd255, 8'hFF, 64'h0);
    check("R11 age 0 older than 255", 64'(fwdMask), 64'hFF);
    check("R11 forwarded data", fwdData, 64'h5555555555555555);
    issueOp(1'b1, 40'h900, 8'd255, 8'hFF, 64'h9);
    issueOp(1'b0, 40'h900, 8'd0, 8'hFF, 64'h0);
    check("R11 age 255 not older than 0", 64'(fwdMask), 64'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule